// File: doc/BRIEF.md
# Ternary Match-Action Header Stage

This block is one stage of a header-processing pipeline. Each cycle it can take a header-field bus of eight 16-bit fields together with a valid bit. It builds a 64-bit search key from four fields of that bus, chosen by configuration. The key is compared against sixteen ternary rules. Each rule holds a value and a per-bit care mask, so one rule expresses one AND-term, and an OR of conditions takes one rule per term. The lowest-numbered matching rule wins. When nothing matches, the stage falls back to a default case numbered one past the last rule.

The winning case number indexes an action memory. Each action entry holds, for every destination field, a source field number and a per-bit write mask. That entry steers a sparse crossbar. Masked destination bits take the chosen source field's bits from the incoming bus. All other bits pass through unchanged. Rules, actions and the key-field selectors are loaded through a single write port. The stage accepts one key per cycle, with a fixed two-cycle latency.

Top module: `tmx_stage`

## Requirements
- R1: When several valid rules match the key, the reported case is the lowest-numbered one among them.
- R2: When no valid rule matches, the case is 16 and action entry 16 is applied.
- R3: A rule matches when, for every key bit whose care bit is 1, the key bit equals the rule value bit. Key bits whose care bit is 0 are ignored.
- R4: A rule whose valid bit is 0 never matches, whatever its value and care fields hold.
- R5: For each destination field d, with action slot mask M and source index S, the output field equals (in[d] & ~M) | (in[S] & M), where in[] is the incoming bus. Field i occupies bus bits [16i+15:16i].
- R6: Key slice k (key bits [16k+15:16k], k = 0..3) is the bus field named by selector k. After reset, selector k names field k.
- R7: A configuration write is applied at the clock edge that samples it. A key sampled at that same edge sees the old contents, and a key sampled at any later edge sees the new contents.
- R8: A key sampled with in_valid high at edge E appears on the outputs with out_valid high after edge E+1. Keys may arrive back to back. While out_valid is low, out_bus and out_case hold their values.
- R9: After reset, out_valid is 0, all rules are invalid and all action entries are zero, so a key reports case 16 and leaves the bus unchanged.
- R10: Write encodings are as follows. cfg_kind 0 writes rule cfg_addr (0..15) with value in data[63:0], care in data[127:64] and valid in data[128]. cfg_kind 1 writes action entry cfg_addr (0..16), where destination slot d uses data[19d+15:19d] as the mask and data[19d+18:19d+16] as the source field. cfg_kind 2 writes selector k from data[3k+2:3k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming bus carries a header |
| in_bus | input | 128 | Incoming header-field bus, eight 16-bit fields |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 rule, 1 action, 2 key selectors |
| cfg_addr | input | 5 | Rule or action entry number |
| cfg_data | input | 152 | Write data, layout per target |
| out_valid | output | 1 | Outgoing bus is valid |
| out_bus | output | 128 | Transformed header-field bus |
| out_case | output | 5 | Winning case number, 16 when nothing matched |

## Verification
The bench places overlapping rules so that a higher-numbered rule also matches. A wrong priority encoder would report the higher number. It plants an invalid rule that would otherwise win, which catches a design that ignores the valid bit. It also uses a rule whose differences from the key fall only in don't-care positions, which catches a design that compares all bits. It issues a rule write and a key in the same cycle and expects the old result, which exposes any bypass path. It remaps the key selectors and partially masks destination fields, so a crossbar that writes whole fields or reads the already-modified bus returns wrong bits. Back-to-back keys with gaps expose any slip in the two-cycle alignment of data and valid.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
    localparam int FIELD_W    = 16;
    localparam int N_FIELDS   = 8;
    localparam int FSEL_W     = $clog2(N_FIELDS);
    localparam int BUS_W      = FIELD_W * N_FIELDS;
    localparam int KEY_SLICES = 4;
    localparam int KEY_W      = FIELD_W * KEY_SLICES;
    localparam int N_RULES    = 16;
    localparam int RIDX_W     = $clog2(N_RULES);
    localparam int N_CASES    = N_RULES + 1;
    localparam int CASE_W     = $clog2(N_CASES);
    localparam int ACT_FLD_W  = FIELD_W + FSEL_W;
    localparam int ACT_W      = ACT_FLD_W * N_FIELDS;
    localparam int RULE_W     = 2 * KEY_W + 1;
    localparam int KSEL_W     = KEY_SLICES * FSEL_W;
    localparam int CFG_W      = (ACT_W > RULE_W) ? ACT_W : RULE_W;

    typedef enum logic [1:0] {
        CFG_RULE = 2'd0,
        CFG_ACT  = 2'd1,
        CFG_KSEL = 2'd2
    } cfg_kind_e;

    typedef struct packed {
        logic             valid;
        logic [KEY_W-1:0] care;
        logic [KEY_W-1:0] value;
    } rule_t;

    typedef struct packed {
        logic [FSEL_W-1:0]  src;
        logic [FIELD_W-1:0] mask;
    } act_fld_t;

    typedef act_fld_t [N_FIELDS-1:0] action_t;

    function automatic logic rule_hit(input rule_t r, input logic [KEY_W-1:0] key);
        return r.valid && (((key ^ r.value) & r.care) == '0);
    endfunction
endpackage

// File: rtl/tmx_rule_table.sv
module tmx_rule_table
    import tmx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [RIDX_W-1:0]        wr_addr,
    input  rule_t                    wr_data,
    input  logic [KEY_W-1:0]         key,
    output logic [N_RULES-1:0]       match_vec,
    output logic [N_RULES-1:0]       grant_vec,
    output logic [CASE_W-1:0]        win_idx
);
    rule_t tbl [N_RULES];

    for (genvar i = 0; i < N_RULES; i++) begin : g_rule
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[i] <= '0;
            end else if (wr_en && wr_addr == RIDX_W'(i)) begin
                tbl[i] <= wr_data;
            end
        end
        assign match_vec[i] = rule_hit(tbl[i], key);
    end

    // Lowest index wins; scan from the top so the last hit written is the smallest.
    always_comb begin
        win_idx   = CASE_W'(N_RULES);
        grant_vec = '0;
        for (int i = N_RULES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                win_idx   = CASE_W'(i);
                grant_vec = N_RULES'(1) << i;
            end
        end
    end
endmodule

// File: rtl/tmx_action_mem.sv
module tmx_action_mem
    import tmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CASE_W-1:0] wr_addr,
    input  action_t           wr_data,
    input  logic [CASE_W-1:0] rd_idx,
    output action_t           rd_data
);
    action_t mem [N_CASES];

    for (genvar e = 0; e < N_CASES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[e] <= '0;
            end else if (wr_en && wr_addr == CASE_W'(e)) begin
                mem[e] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int e = 0; e < N_CASES; e++) begin
            if (rd_idx == CASE_W'(e)) rd_data = mem[e];
        end
    end
endmodule

// File: rtl/tmx_field_xbar.sv
module tmx_field_xbar
    import tmx_pkg::*;
(
    input  logic [BUS_W-1:0] in_bus,
    input  action_t          act,
    output logic [BUS_W-1:0] out_bus
);
    for (genvar d = 0; d < N_FIELDS; d++) begin : g_dst
        logic [FIELD_W-1:0] src_fld;
        logic [FIELD_W-1:0] own_fld;
        assign src_fld = in_bus[act[d].src * FIELD_W +: FIELD_W];
        assign own_fld = in_bus[d * FIELD_W +: FIELD_W];
        assign out_bus[d * FIELD_W +: FIELD_W] =
            (own_fld & ~act[d].mask) | (src_fld & act[d].mask);
    end
endmodule

// File: rtl/tmx_stage.sv
module tmx_stage
    import tmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BUS_W-1:0]  in_bus,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [CASE_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic              out_valid,
    output logic [BUS_W-1:0]  out_bus,
    output logic [CASE_W-1:0] out_case
);
    cfg_kind_e kind;
    assign kind = cfg_kind_e'(cfg_kind);

    logic rule_we, act_we, ksel_we;
    assign rule_we = cfg_we && kind == CFG_RULE && cfg_addr < CASE_W'(N_RULES);
    assign act_we  = cfg_we && kind == CFG_ACT  && cfg_addr < CASE_W'(N_CASES);
    assign ksel_we = cfg_we && kind == CFG_KSEL;

    // Key field selectors
    logic [FSEL_W-1:0] ksel_q [KEY_SLICES];
    logic [KEY_W-1:0]  key;

    for (genvar k = 0; k < KEY_SLICES; k++) begin : g_key
        always_ff @(posedge clk) begin
            if (rst) begin
                ksel_q[k] <= FSEL_W'(k);
            end else if (ksel_we) begin
                ksel_q[k] <= cfg_data[k * FSEL_W +: FSEL_W];
            end
        end
        assign key[k * FIELD_W +: FIELD_W] = in_bus[ksel_q[k] * FIELD_W +: FIELD_W];
    end

    logic [N_RULES-1:0] match_vec, grant_vec;
    logic [CASE_W-1:0]  win_idx;
    action_t            act_rd;

    tmx_rule_table u_rules (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (rule_we),
        .wr_addr   (cfg_addr[RIDX_W-1:0]),
        .wr_data   (rule_t'(cfg_data[RULE_W-1:0])),
        .key       (key),
        .match_vec (match_vec),
        .grant_vec (grant_vec),
        .win_idx   (win_idx)
    );

    tmx_action_mem u_acts (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (act_we),
        .wr_addr (cfg_addr),
        .wr_data (action_t'(cfg_data[ACT_W-1:0])),
        .rd_idx  (win_idx),
        .rd_data (act_rd)
    );

    // Stage 1: match result, fetched command and delayed bus
    logic              s1_valid;
    logic [BUS_W-1:0]  s1_bus;
    logic [CASE_W-1:0] s1_case;
    action_t           s1_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_bus   <= '0;
            s1_case  <= '0;
            s1_act   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_bus  <= in_bus;
                s1_case <= win_idx;
                s1_act  <= act_rd;
            end
        end
    end

    // Stage 2: masked field assignment
    logic [BUS_W-1:0] xbar_bus;

    tmx_field_xbar u_xbar (
        .in_bus  (s1_bus),
        .act     (s1_act),
        .out_bus (xbar_bus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bus   <= '0;
            out_case  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_bus  <= xbar_bus;
                out_case <= s1_case;
            end
        end
    end
endmodule

// File: rtl/tmx_stage_chk.sv
module tmx_stage_chk
    import tmx_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               out_valid,
    input logic [BUS_W-1:0]   out_bus,
    input logic [CASE_W-1:0]  out_case,
    input logic [N_RULES-1:0] match_vec,
    input logic [N_RULES-1:0] grant_vec,
    input logic [CASE_W-1:0]  win_idx
);
    logic [1:0] up;
    always_ff @(posedge clk) begin
        if (rst) up <= '0;
        else if (up != 2'd2) up <= up + 2'd1;
    end

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        (up == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (up == 2'd2 && !out_valid) |-> ($stable(out_bus) && $stable(out_case)));

    p_lowest_grant_r1: assert property (@(posedge clk) disable iff (rst)
        (|match_vec) |-> ($countones(grant_vec) == 1 && (grant_vec & match_vec) == grant_vec
                          && ((grant_vec - 1'b1) & match_vec) == '0));

    p_default_case_r2: assert property (@(posedge clk) disable iff (rst)
        (match_vec == '0) |-> (win_idx == CASE_W'(N_RULES)));

    p_case_range_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_case <= CASE_W'(N_RULES)));
endmodule

bind tmx_stage tmx_stage_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_bus   (out_bus),
    .out_case  (out_case),
    .match_vec (match_vec),
    .grant_vec (grant_vec),
    .win_idx   (win_idx)
);

// File: tb/tb_tmx_stage.sv
module tb_tmx_stage;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_bus;
    logic         cfg_we;
    logic [1:0]   cfg_kind;
    logic [4:0]   cfg_addr;
    logic [151:0] cfg_data;
    logic         out_valid;
    logic [127:0] out_bus;
    logic [4:0]   out_case;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmx_stage dut (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Bench-side model of the configuration
    logic        m_valid [16];
    logic [63:0] m_val [16];
    logic [63:0] m_care [16];
    logic [151:0] m_act [17];
    int          m_ksel [4];

    logic [127:0] q_bus [$];
    logic [4:0]   q_case [$];
    int           q_cyc [$];
    string        q_tag [$];

    function automatic logic [15:0] fld(input logic [127:0] b, input int i);
        return b[i*16 +: 16];
    endfunction

    function automatic logic [127:0] fb(input int i, input logic [15:0] v);
        logic [127:0] r = '0;
        r[i*16 +: 16] = v;
        return r;
    endfunction

    function automatic logic [4:0] model_case(input logic [127:0] b);
        logic [63:0] key;
        for (int k = 0; k < 4; k++) key[k*16 +: 16] = fld(b, m_ksel[k]);
        for (int i = 0; i < 16; i++)
            if (m_valid[i] && (((key ^ m_val[i]) & m_care[i]) == 64'd0)) return 5'(i);
        return 5'd16;
    endfunction

    function automatic logic [127:0] model_bus(input logic [127:0] b, input logic [4:0] c);
        logic [127:0] r;
        for (int d = 0; d < 8; d++) begin
            logic [15:0] m;
            int s;
            m = m_act[c][d*19 +: 16];
            s = int'(m_act[c][d*19+16 +: 3]);
            r[d*16 +: 16] = (fld(b, d) & ~m) | (fld(b, s) & m);
        end
        return r;
    endfunction

    function automatic logic [151:0] rule_word(input logic v, input logic [63:0] care,
                                                input logic [63:0] val);
        return {23'd0, v, care, val};
    endfunction

    function automatic logic [151:0] act_slot(input int d, input int src, input logic [15:0] m);
        logic [151:0] r = '0;
        r[d*19 +: 16]    = m;
        r[d*19+16 +: 3]  = 3'(src);
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: optional config write and optional key, driven after a falling edge
    task automatic step(input logic we, input logic [1:0] kind, input logic [4:0] addr,
                        input logic [151:0] data, input logic v, input logic [127:0] bus,
                        input string tag);
        cfg_we = we; cfg_kind = kind; cfg_addr = addr; cfg_data = data;
        in_valid = v; in_bus = bus;
        if (v) begin
            logic [4:0] c;
            c = model_case(bus);
            q_case.push_back(c);
            q_bus.push_back(model_bus(bus, c));
            q_cyc.push_back(cyc + 2);
            q_tag.push_back(tag);
        end
        if (we) begin
            if (kind == 2'd0 && addr < 16) begin
                m_val[addr] = data[63:0]; m_care[addr] = data[127:64]; m_valid[addr] = data[128];
            end else if (kind == 2'd1 && addr < 17) begin
                m_act[addr] = data;
            end else if (kind == 2'd2) begin
                for (int k = 0; k < 4; k++) m_ksel[k] = int'(data[k*3 +: 3]);
            end
        end
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
    endtask

    task automatic key(input logic [127:0] bus, input string tag);
        step(1'b0, 2'd0, 5'd0, '0, 1'b1, bus, tag);
    endtask

    task automatic wr(input logic [1:0] kind, input logic [4:0] addr, input logic [151:0] data);
        step(1'b1, kind, addr, data, 1'b0, '0, "R10");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 5'd0, '0, 1'b0, '0, "");
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_case.size() == 0) begin
                check(1'b0, "R8", "unexpected out_valid", 128'(out_case), 128'(0));
            end else begin
                logic [127:0] eb;
                logic [4:0]   ec;
                int           ey;
                string        t;
                eb = q_bus.pop_front(); ec = q_case.pop_front();
                ey = q_cyc.pop_front(); t = q_tag.pop_front();
                check(out_case == ec, t, "case", 128'(out_case), 128'(ec));
                check(out_bus == eb, t, "bus", out_bus, eb);
                check(cyc == ey, "R8", "latency cycle", 128'(cyc), 128'(ey));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_valid[i] = 0; m_val[i] = '0; m_care[i] = '0; end
        for (int i = 0; i < 17; i++) m_act[i] = '0;
        for (int k = 0; k < 4; k++) m_ksel[k] = k;
        rst = 1'b1; in_valid = 1'b0; in_bus = '0;
        cfg_we = 1'b0; cfg_kind = '0; cfg_addr = '0; cfg_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R9", "out_valid after reset", 128'(out_valid), 128'(0));

        // R9: empty tables pass the bus through with the default case
        key(fb(0, 16'h1234) | fb(3, 16'hBEEF), "R9");
        idle(2);

        // R1/R3/R4 rule set
        wr(2'd0, 5'd3, rule_word(1'b1, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_1234));
        wr(2'd0, 5'd5, rule_word(1'b1, 64'h0, 64'hDEAD_BEEF_0BAD_F00D));
        wr(2'd0, 5'd2, rule_word(1'b0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_1234));
        key(fb(0, 16'h1234), "R1");                           // rule 3 beats 5, not 2 (R4)
        key(fb(0, 16'h9999), "R3");                           // only don't-care rule 5
        key(fb(0, 16'h1235), "R3");                           // one cared bit differs
        wr(2'd0, 5'd1, rule_word(1'b1, 64'h00F0_0000_0000_0000, 64'h00A0_0000_0000_0000));
        key(fb(0, 16'h1234) | fb(3, 16'h12A7), "R1");         // rule 1 wins over 3
        key(fb(0, 16'h1234) | fb(3, 16'h12B7), "R3");         // rule 1 cared nibble differs
        key(fb(0, 16'h1234) | fb(2, 16'h7777), "R4");         // invalid rule 2 skipped

        // R5: masked crossbar on case 3
        wr(2'd1, 5'd3, act_slot(1, 0, 16'h00FF) | act_slot(6, 3, 16'hF0F0) | act_slot(0, 6, 16'h0001));
        key(fb(0, 16'h1234) | fb(1, 16'hABCD) | fb(3, 16'h5678) | fb(6, 16'h0F0E), "R5");
        key(fb(0, 16'h1234) | fb(1, 16'hFFFF) | fb(3, 16'hFFFF) | fb(6, 16'h0000), "R5");

        // R6: slice 0 taken from field 7
        wr(2'd2, 5'd0, 152'({3'd3, 3'd2, 3'd1, 3'd7}));
        key(fb(7, 16'h1234), "R6");
        key(fb(0, 16'h1234), "R6");

        // R7: write and key in the same cycle, then key again
        step(1'b1, 2'd0, 5'd0, rule_word(1'b1, 64'h0, 64'h0), 1'b1, fb(7, 16'h1234), "R7");
        key(fb(7, 16'h1234), "R7");

        // R8: back to back with gaps
        key(fb(7, 16'h0001) | fb(4, 16'h1111), "R8");
        key(fb(7, 16'h1234) | fb(4, 16'h2222), "R8");
        key(fb(7, 16'h0003), "R8");
        idle(1);
        key(fb(7, 16'h1234) | fb(1, 16'h4444), "R8");
        idle(3);
        check(out_valid == 1'b0, "R8", "out_valid after drain", 128'(out_valid), 128'(0));

        // R2: no match falls back to entry 16
        wr(2'd0, 5'd0, rule_word(1'b0, 64'h0, 64'h0));
        wr(2'd0, 5'd5, rule_word(1'b0, 64'h0, 64'h0));
        wr(2'd1, 5'd16, act_slot(2, 4, 16'hFFFF));
        key(fb(2, 16'h0102) | fb(4, 16'hCAFE) | fb(7, 16'h4321), "R2");
        key(fb(7, 16'h1234) | fb(2, 16'h0102) | fb(4, 16'hCAFE), "R2");
        idle(4);

        check(q_case.size() == 0, "R8", "results outstanding", 128'(q_case.size()), 128'(0));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule